// File: doc/BRIEF.md
# Flash Command Interface with Program Engine and Status Register

This block models the device side of a NOR-style flash word port. The host drives active-low chip-enable, output-enable and write-enable strobes, a word address and a 16-bit data bus. Bytes written on the low data lane are decoded as commands. The commands switch the read path between a 16-word storage array and an 8-bit status register. They also start, suspend and resume a program operation, and they clear error flags.

Programming takes two writes. The first write is the program-setup code and the second carries the target word address and data. An internal engine then runs for a fixed, parameterised number of clock cycles. At the end it ANDs the new data into the stored word, so a program can only turn ones into zeros. Error flags are sticky, which lets a host run a batch of programs and check the flags once at the end. A status value is captured when a read begins and is held until the host starts a new read by toggling a strobe.

Strobes are sampled on the system clock. A write is taken on the clock cycle in which write-enable is seen returning high while chip-enable is low. A read is active while chip-enable and output-enable are both low. Outside a read the data output is zero.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset every array word reads FFFFh, the read path selects the array, and the status register holds 80h.
- R2: Writing 70h selects status reads. Reads keep returning status until a different recognised command changes the path, and bits 15..8 read as zero during status reads.
- R3: Writing FFh selects array reads, except while a program is running.
- R4: Writing 40h followed by a write carrying address A and data D stores old(A) AND D at A. A one written over a zero leaves the zero in place and sets no error bit. After a program the read path selects status.
- R5: Status bit 7 reads 0 for the PROG_CYCLES cycles that a program runs, and reads 1 otherwise.
- R6: If the supply-low input is high at the data write, status bit 3 is set and the array is not changed.
- R7: If the lock input is high at the data write, status bit 1 is set and the array is not changed.
- R8: If the fail-injection input is high at the data write, status bit 4 is set when the program ends and the array is not changed.
- R9: Status bits 1, 3, 4 and 5 stay set through later operations. They clear only when 50h is written while the engine is idle.
- R10: The status value is captured at the start of a read. While both strobes stay low the output does not change, and a new value appears only after output-enable or chip-enable is toggled.
- R11: Writing B0h during a program halts it at the next checkpoint (remaining count a multiple of 2^CKPT_LG). The status then reads bit 7 = 1 and bit 2 = 1. FFh may be used to read the array while the program is halted. Writing D0h clears bit 2 and finishes the remaining cycles, which writes the word.
- R12: While a program runs, writes other than 70h and B0h are ignored. While it is suspended, 40h and 50h are ignored.
- R13: Writing an unrecognised code leaves the read path unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken when it returns high |
| addr | input | 4 | Word address |
| din | input | 16 | Write data; bits 7..0 carry the command code |
| dout | output | 16 | Read data; zero when no read is active |
| blk_locked | input | 1 | Target block is locked |
| supply_low | input | 1 | Program supply is below its limit |
| force_fail | input | 1 | Makes the next program report a failure |

## Verification
The bench programs every address twice with computed patterns, in array order and again with ones placed over existing zeros. A design that overwrote the word instead of ANDing would show stale ones, and one that flagged the ones-over-zeros case would raise bit 4. It holds output-enable low across a whole program to catch a status path that tracks the live value instead of the value captured when the read started. It also suspends a program while older error flags are set. It then tries clear and read-array writes at points where they must be ignored, which exposes a design that forgets the remaining count, clears flags during an operation, or loses the sticky bits.

// File: rtl/fci_pkg.sv
// Package: command codes, read-path modes and engine states shared by the
// flash command interface. Assumes an 8-bit command on data lane 7..0.
package fci_pkg;
    typedef enum logic {
        RD_ARRAY  = 1'b0,
        RD_STATUS = 1'b1
    } rd_mode_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RUN  = 2'd1,
        WS_SUSP = 2'd2
    } ws_state_e;

    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR_FLAGS = 8'h50;
    localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_RESUME      = 8'hD0;
endpackage

// File: rtl/fci_bus_sense.sv
// Strobe sensing: turns the asynchronous-looking flash strobes (sampled on
// clk) into a one-cycle write event and read-active / read-start flags.
// Assumes the strobes are already synchronous to clk.
module fci_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_evt,
    output logic rd_act,
    output logic rd_start
);
    logic we_q;
    logic rd_q;

    // Remember last sampled write strobe and read-active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            rd_q <= 1'b0;
        end else begin
            we_q <= we_n;
            rd_q <= rd_act;
        end
    end

    // Write taken on the cycle write-enable is seen rising with chip enabled.
    always_comb begin
        rd_act   = !ce_n && !oe_n;
        rd_start = rd_act && !rd_q;
        wr_evt   = !we_q && we_n && !ce_n;
    end
endmodule

// File: rtl/fci_cmd_decode.sv
// Command decoder: interprets each bus write as a command or, after the
// program-setup code, as program address/data. Owns the read-path mode.
// Assumes engine state flags are registered outputs of the engine.
module fci_cmd_decode
    import fci_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_evt,
    input  logic [7:0] cmd,
    input  logic     ws_idle,
    input  logic     ws_run,
    input  logic     ws_susp,
    output rd_mode_e rd_mode,
    output logic     start,
    output logic     clr,
    output logic     susp_req,
    output logic     resume
);
    logic armed_q;
    logic is_cmd;

    // Strobe outputs that act on the engine in the same cycle.
    always_comb begin
        is_cmd   = wr_evt && !armed_q;
        start    = wr_evt && armed_q;
        clr      = is_cmd && (cmd == OP_CLEAR_FLAGS) && ws_idle;
        susp_req = is_cmd && (cmd == OP_SUSPEND) && ws_run;
        resume   = is_cmd && (cmd == OP_RESUME) && ws_susp;
    end

    // Track read-path mode and the program-setup arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mode <= RD_ARRAY;
            armed_q <= 1'b0;
        end else if (start) begin
            armed_q <= 1'b0;
            rd_mode <= RD_STATUS;
        end else if (is_cmd) begin
            case (cmd)
                OP_READ_STATUS: rd_mode <= RD_STATUS;
                OP_READ_ARRAY:  if (!ws_run) rd_mode <= RD_ARRAY;
                OP_PROG_SETUP:  if (ws_idle) armed_q <= 1'b1;
                OP_SUSPEND:     if (ws_run) rd_mode <= RD_STATUS;
                OP_RESUME:      if (ws_susp) rd_mode <= RD_STATUS;
                default:        ;
            endcase
        end
    end

    AST_ARRAY_CMD_IGNORED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && (cmd == OP_READ_ARRAY) && ws_run) |=> (rd_mode == RD_STATUS)); // R12
    AST_UNKNOWN_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && (cmd == 8'h12)) |=> (rd_mode == $past(rd_mode))); // R13
endmodule

// File: rtl/fci_prog_engine.sv
// Program engine: runs a fixed-length program count, honours suspend at
// checkpoints and resume, and keeps the sticky status flags. Assumes
// PROG_CYCLES >= 2 and CKPT_LG >= 1.
module fci_prog_engine
    import fci_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 64,
    parameter int CKPT_LG     = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              clr,
    input  logic              susp_req,
    input  logic              resume,
    input  logic              supply_low,
    input  logic              blk_locked,
    input  logic              force_fail,
    output logic              ws_idle,
    output logic              ws_run,
    output logic              ws_susp,
    output logic [7:0]        status,
    output logic              arr_we,
    output logic [AW-1:0]     arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    ws_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             fail_q;
    logic             err_lock_q, err_vlow_q, err_prog_q, err_erase_q;
    logic             finish;
    logic             at_ckpt;

    // Decode engine state and completion.
    always_comb begin
        ws_idle = (state_q == WS_IDLE);
        ws_run  = (state_q == WS_RUN);
        ws_susp = (state_q == WS_SUSP);
        finish  = ws_run && (cnt_q == CNT_W'(1));
        at_ckpt = (cnt_q[CKPT_LG-1:0] == '0);
        arr_we  = finish && !fail_q;
        status  = {!ws_run, 1'b0, err_erase_q, err_prog_q, err_vlow_q, ws_susp, err_lock_q, 1'b0};
    end

    // State, counter, suspend pending and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            fail_q   <= 1'b0;
            arr_addr <= '0;
            arr_data <= '0;
        end else begin
            case (state_q)
                WS_IDLE: if (start && !supply_low && !blk_locked) begin
                    state_q  <= WS_RUN;
                    cnt_q    <= CNT_W'(PROG_CYCLES);
                    pend_q   <= 1'b0;
                    fail_q   <= force_fail;
                    arr_addr <= in_addr;
                    arr_data <= in_data;
                end
                WS_RUN: begin
                    if (finish) begin
                        state_q <= WS_IDLE;
                        pend_q  <= 1'b0;
                    end else if ((pend_q || susp_req) && at_ckpt) begin
                        state_q <= WS_SUSP;
                        pend_q  <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (susp_req) pend_q <= 1'b1;
                    end
                end
                WS_SUSP: if (resume) state_q <= WS_RUN;
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // Sticky error flags: set by the engine, cleared only by clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_lock_q  <= 1'b0;
            err_vlow_q  <= 1'b0;
            err_prog_q  <= 1'b0;
            err_erase_q <= 1'b0;
        end else if (clr) begin
            err_lock_q  <= 1'b0;
            err_vlow_q  <= 1'b0;
            err_prog_q  <= 1'b0;
            err_erase_q <= 1'b0;
        end else begin
            if (start && ws_idle && supply_low) err_vlow_q <= 1'b1;
            if (start && ws_idle && !supply_low && blk_locked) err_lock_q <= 1'b1;
            if (finish && fail_q) err_prog_q <= 1'b1;
        end
    end

    AST_VLOW_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ws_idle && supply_low) |=> (ws_idle && status[3])); // R6
    AST_LOCK_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ws_idle && !supply_low && blk_locked) |=> (ws_idle && status[1])); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status[5:3] & $past(status[5:3])) == $past(status[5:3]) && (status[1] || !$past(status[1])))); // R9
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status[5:3] == 3'b000 && !status[1])); // R9
    AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_run && $past(ws_susp)) |-> $past(resume)); // R11
endmodule

// File: rtl/fci_word_array.sv
// Word array: DEPTH words, reset to all ones, written by AND so that a
// program can only clear bits. Combinational read port.
module fci_word_array #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [AW-1:0]     ra,
    output logic [DATA_W-1:0] rd
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Erase to ones on reset; AND new data into the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[wa] <= mem[wa] & wd;
        end
    end

    // Read port.
    assign rd = mem[ra];

    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(wa)] & ~$past(mem[wa])) == '0)); // R4
endmodule

// File: rtl/flash_cmd_if.sv
// Top: flash word interface with command decoder, program engine, word
// array and a status value captured at the start of each read.
// Assumes strobes synchronous to clk; DATA_W >= 8.
module flash_cmd_if
    import fci_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 64,
    parameter int CKPT_LG     = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic              blk_locked,
    input  logic              supply_low,
    input  logic              force_fail
);
    logic              wr_evt, rd_act, rd_start;
    rd_mode_e          rd_mode;
    logic              start, clr, susp_req, resume;
    logic              ws_idle, ws_run, ws_susp;
    logic [7:0]        live_status;
    logic [7:0]        held_status;
    logic              arr_we;
    logic [AW-1:0]     arr_addr;
    logic [DATA_W-1:0] arr_data;
    logic [DATA_W-1:0] arr_rd;

    fci_bus_sense i_sense (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wr_evt(wr_evt), .rd_act(rd_act), .rd_start(rd_start)
    );

    fci_cmd_decode i_decode (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .cmd(din[7:0]),
        .ws_idle(ws_idle), .ws_run(ws_run), .ws_susp(ws_susp),
        .rd_mode(rd_mode), .start(start), .clr(clr),
        .susp_req(susp_req), .resume(resume)
    );

    fci_prog_engine #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES), .CKPT_LG(CKPT_LG)
    ) i_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .in_addr(addr), .in_data(din),
        .clr(clr), .susp_req(susp_req), .resume(resume),
        .supply_low(supply_low), .blk_locked(blk_locked), .force_fail(force_fail),
        .ws_idle(ws_idle), .ws_run(ws_run), .ws_susp(ws_susp), .status(live_status),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    fci_word_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .wa(arr_addr), .wd(arr_data),
        .ra(addr), .rd(arr_rd)
    );

    // Capture the live status at the start of each read.
    always_ff @(posedge clk) begin
        if (!rst_n) held_status <= 8'h80;
        else if (rd_start) held_status <= live_status;
    end

    // Output mux: zero when idle, status (upper byte zero) or array word.
    always_comb begin
        if (!rd_act) dout = '0;
        else if (rd_mode == RD_STATUS)
            dout = {{(DATA_W-8){1'b0}}, (rd_start ? live_status : held_status)};
        else dout = arr_rd;
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && rd_mode == RD_STATUS) |-> (dout[DATA_W-1:8] == '0)); // R2
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !rd_start && rd_mode == RD_STATUS && $past(rd_mode == RD_STATUS) && $past(rd_act))
        |-> $stable(dout)); // R10
endmodule

// File: tb/test_flash_cmd_if.sv
// Bench: sweeps programs over every address with computed patterns and
// walks the status, suspend and error-flag corner cases.
module test_flash_cmd_if;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        blk_locked = 1'b0, supply_low = 1'b0, force_fail = 1'b0;

    int vectors = 0;
    int misses = 0;
    int cyc = 0;
    logic [15:0] exp_mem [16];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_if #(.PROG_CYCLES(N), .CKPT_LG(2)) i_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout),
        .blk_locked(blk_locked), .supply_low(supply_low), .force_fail(force_fail)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        vectors++;
        if (act !== expv) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        addr = a; din = d; we_n = 1'b0;
        @(posedge clk); #2;
        we_n = 1'b1;
        @(posedge clk); #2;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        addr = a; oe_n = 1'b0;
        @(posedge clk); #2;
        d = dout; oe_n = 1'b1;
        @(posedge clk); #2;
    endtask

    task automatic poll_ready(output logic [15:0] d, output int took);
        int t0;
        t0 = cyc;
        d = '0;
        for (int k = 0; k < 40; k++) begin
            bus_read(0, d);
            if (d[7]) break;
        end
        took = cyc - t0;
    endtask

    task automatic program_word(input logic [3:0] a, input logic [15:0] d);
        bus_write(0, 16'h0040);
        bus_write(a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int          took;
        for (int i = 0; i < 16; i++) exp_mem[i] = 16'hFFFF;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        // R1: reset state
        bus_read(0, r);  check("R1 array word 0", r, 16'hFFFF);
        bus_read(15, r); check("R1 array word 15", r, 16'hFFFF);
        bus_write(0, 16'h0070);
        bus_read(0, r);  check("R1 status after reset", r, 16'h0080);
        // R13: unknown code in status mode
        bus_write(0, 16'h0012);
        bus_read(3, r);  check("R13 status mode kept", r, 16'h0080);
        // R3 and R13 in array mode
        bus_write(0, 16'h00FF);
        bus_read(3, r);  check("R3 array read", r, 16'hFFFF);
        bus_write(0, 16'h0012);
        bus_read(3, r);  check("R13 array mode kept", r, 16'hFFFF);

        // R4/R5 sweep: two rounds over all addresses
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int a = 0; a < 16; a++) begin
                logic [15:0] pat;
                pat = (rnd == 0) ? ~(16'(a) * 16'h0911) : ({4{4'(a)}} ^ 16'h5A5A);
                program_word(4'(a), pat);
                if (rnd == 0 && a == 0) begin
                    bus_read(0, r); check("R5 busy right after start", r, 16'h0000);
                end
                poll_ready(r, took);
                check("R4 status no error", r, 16'h0080);
                if (rnd == 0 && a == 0) begin
                    vectors++;
                    if (took < N - 4 || took > N + 2) begin
                        misses++;
                        $display("FAIL R5 busy length actual=%0d expected=%0d..%0d", took, N - 4, N + 2);
                    end
                end
                exp_mem[a] = exp_mem[a] & pat;
            end
            bus_write(0, 16'h00FF);
            for (int a = 0; a < 16; a++) begin
                bus_read(4'(a), r);
                check("R4 stored old AND new", r, exp_mem[a]);
            end
        end

        // R10: status held while strobes stay low
        program_word(2, 16'hFFF0);
        exp_mem[2] = exp_mem[2] & 16'hFFF0;
        addr = 0; oe_n = 1'b0;
        repeat (2) @(posedge clk); #2;
        check("R10 busy captured", dout, 16'h0000);
        repeat (N + 4) @(posedge clk); #2;
        check("R10 stale while held", dout, 16'h0000);
        ce_n = 1'b1; @(posedge clk); #2;
        ce_n = 1'b0; @(posedge clk); #2;
        check("R10 fresh after ce toggle", dout, 16'h0080);
        oe_n = 1'b1; @(posedge clk); #2;

        // R6: supply low
        supply_low = 1'b1;
        program_word(4, 16'h0000);
        supply_low = 1'b0;
        bus_read(0, r); check("R6 status bit 3", r, 16'h0088);
        bus_write(0, 16'h00FF);
        bus_read(4, r); check("R6 word unchanged", r, exp_mem[4]);

        // R9: sticky through a good program
        program_word(5, 16'h0F0F);
        exp_mem[5] = exp_mem[5] & 16'h0F0F;
        poll_ready(r, took);
        check("R9 bit 3 persists", r, 16'h0088);
        // R7: locked block
        blk_locked = 1'b1;
        program_word(6, 16'h0000);
        blk_locked = 1'b0;
        bus_read(0, r); check("R7 status bit 1", r, 16'h008A);
        bus_write(0, 16'h00FF);
        bus_read(6, r); check("R7 word unchanged", r, exp_mem[6]);
        bus_read(5, r); check("R9 good program landed", r, exp_mem[5]);

        // R12/R11: ignored writes, suspend, resume
        program_word(7, 16'h00FF);
        bus_write(0, 16'h0050);
        bus_write(0, 16'h00FF);
        bus_read(0, r); check("R12 clear and FF ignored while running", r, 16'h000A);
        bus_write(0, 16'h00B0);
        poll_ready(r, took);
        check("R11 suspended status", r, 16'h008E);
        bus_write(0, 16'h0050);
        bus_read(0, r); check("R12 clear ignored while suspended", r, 16'h008E);
        bus_write(0, 16'h00FF);
        bus_read(7, r); check("R11 array read while suspended", r, exp_mem[7]);
        bus_read(5, r); check("R11 other word while suspended", r, exp_mem[5]);
        bus_write(0, 16'h0070);
        bus_read(0, r); check("R2 status again", r, 16'h008E);
        bus_write(0, 16'h00D0);
        bus_read(0, r); check("R11 resumed busy", r, 16'h000A);
        poll_ready(r, took);
        check("R11 resumed done", r, 16'h008A);
        exp_mem[7] = exp_mem[7] & 16'h00FF;
        bus_write(0, 16'h00FF);
        bus_read(7, r); check("R11 word written after resume", r, exp_mem[7]);
        bus_write(0, 16'h0050);
        bus_write(0, 16'h0070);
        bus_read(0, r); check("R9 clear when idle", r, 16'h0080);

        // R8: injected failure
        force_fail = 1'b1;
        program_word(8, 16'h0000);
        force_fail = 1'b0;
        poll_ready(r, took);
        check("R8 status bit 4", r, 16'h0090);
        bus_write(0, 16'h00FF);
        bus_read(8, r); check("R8 word unchanged", r, exp_mem[8]);
        bus_write(0, 16'h0050);
        bus_write(0, 16'h0070);
        bus_read(0, r); check("R9 bit 4 cleared", r, 16'h0080);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule